// File: doc/BRIEF.md
# Byte-Wide Prefetching Bus Interface

This block connects a 16-bit execution core to an 8-bit external memory bus. The core issues byte or word data requests as a segment, an offset, a direction and write data. The block turns each request into one or two byte-wide bus cycles and returns the assembled read data. Each physical address is 20 bits wide and is built from a segment and an offset.

When no data request is waiting, the block fetches code bytes ahead of the core into a four-entry byte queue. It starts at a code segment and fetch pointer. The core takes bytes from the queue through a valid/ready handshake. The core can report a control transfer with a new code segment and pointer. The queue is then emptied and fetching starts again at the new place, and any byte already on the bus from the old stream is thrown away.

Each bus cycle has four states plus any wait states. The external side can stretch a cycle by holding its ready input low. It can also take the bus away through a hold request. The block finishes its current cycle, raises acknowledge, and stops driving address, data and strobes until hold is removed.

Top module: `bytebus_biu`

## Requirements
- R1: The physical address on `bus_addr` is (segment × 16 + offset) modulo 2^20. This holds for data cycles (`req_seg`, `req_off`) and for code fetches (current code segment and fetch pointer).
- R2: A word request runs two byte cycles, first at offset off and then at off+1, with the offset wrapping within 16 bits. A read returns {second byte, first byte} on `rsp_rdata`. A byte request runs one cycle and returns {8'h00, byte}. A write drives `req_wdata[7:0]` first and then `req_wdata[15:8]`. `rsp_valid` pulses once per request.
- R3: Each bus cycle has `bus_ale` high for one clock (T1) with the address valid. It then holds `bus_rd` or `bus_wr` (never both) high from the next clock until the data phase ends. This is followed by one clock with both strobes low (T4), so a cycle with no wait states lasts four clocks.
- R4: `bus_ready` is sampled on every clock from the third clock of a cycle onward. Each low sample adds one clock. Read data on `bus_din` is taken on the clock where ready is sampled high. A strobe therefore lasts 2 + (number of low samples) clocks.
- R5: When no data request is pending and the queue holds fewer than 4 bytes, a new cycle fetches the byte at the code segment and fetch pointer, and the pointer then advances by one.
- R6: A data request pending at a cycle boundary, including one accepted on that very clock, is served before any prefetch. The first address cycle started after a request is accepted belongs to that request. A cycle in progress is never cut short.
- R7: The queue holds at most 4 bytes and hands them out in fetch order. `q_valid` is high whenever it is not empty, and a byte is consumed when `q_valid` and `q_ready` are both high.
- R8: A clock with `jmp_valid` high empties the queue, so `q_valid` is low on the next clock. A pop in that clock has no effect. After it, every byte delivered comes from `jmp_seg`/`jmp_off` onward, and a fetch in flight from the old stream is dropped.
- R9: `hlda` rises only at a cycle boundary, never during T1 to T3 or a wait state, and `hold` takes priority over new cycles there. While `hlda` is high, `bus_drive` is low and all strobes are low. `hlda` falls on the clock after `hold` is seen low.
- R10: During reset, `hlda`, `q_valid`, `rsp_valid`, `bus_ale`, `bus_rd` and `bus_wr` are low, and `req_ready` and `bus_drive` are high. Fetching starts at segment 16'hF000, pointer 16'h0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core data request present |
| req_ready | output | 1 | Block can accept a data request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_seg | input | 16 | Data segment |
| req_off | input | 16 | Data offset |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read result |
| jmp_valid | input | 1 | Control transfer: flush and redirect fetching |
| jmp_seg | input | 16 | New code segment |
| jmp_off | input | 16 | New fetch pointer |
| q_valid | output | 1 | Queue has a byte |
| q_ready | input | 1 | Core takes the presented byte |
| q_byte | output | 8 | Oldest queued code byte |
| bus_addr | output | 20 | Physical address |
| bus_dout | output | 8 | Write data to memory |
| bus_din | input | 8 | Read data from memory |
| bus_ale | output | 1 | Address phase strobe (T1) |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe, data valid on bus_dout |
| bus_ready | input | 1 | Memory ready; low inserts wait states |
| bus_drive | output | 1 | 1 = block drives address, data and strobes |
| hold | input | 1 | Another master requests the bus |
| hlda | output | 1 | Bus released to the other master |

## Verification
A data request can be accepted on the same clock at which a prefetch would start. The random stimulus makes this happen by issuing requests while the queue has free space. Queue consumption is random, so boundary decisions often find both a pending request and room in the queue. The judgement is that the first address phase seen after acceptance carries the request's address. A control transfer can also land while a code byte is on the bus or being pushed. Pops are compared against a bench-side model of the fetch pointer, so any stale byte from that cycle shows up as a data mismatch.

// File: rtl/biu_pkg.sv
package biu_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_st_e;
endpackage

// File: rtl/biu_addr_gen.sv
module biu_addr_gen #(
  parameter int SEG_W = 16,
  parameter int OFF_W = 16,
  parameter int SHIFT = 4,
  parameter int PA_W  = 20
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  output logic [PA_W-1:0]  pa
);
  logic [PA_W-1:0] seg_ext;
  logic [PA_W-1:0] off_ext;

  always_comb begin
    seg_ext = PA_W'(seg) << SHIFT;
    off_ext = PA_W'(off);
    pa      = seg_ext + off_ext;
  end
endmodule

// File: rtl/biu_prefetch_q.sv
module biu_prefetch_q #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop_req,
  output logic         not_empty,
  output logic         has_room,
  output logic [W-1:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;
  logic          pop;

  assign not_empty = (count != '0);
  assign has_room  = (count < CW'(DEPTH));
  assign head      = mem[rp];
  assign pop       = pop_req && not_empty && !flush;

  function automatic logic [AW-1:0] inc_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= inc_ptr(wp);
      if (pop)  rp <= inc_ptr(rp);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: a push never lands on a full queue
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> (count < CW'(DEPTH)));
  // R8: a flush leaves the queue empty on the next clock
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !not_empty);
endmodule

// File: rtl/biu_bus_seq.sv
module biu_bus_seq
  import biu_pkg::*;
#(
  parameter int PA_W = 20,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic            bus_ready,
  input  logic            data_pend,
  input  logic            fetch_ok,
  input  logic [PA_W-1:0] data_addr,
  input  logic            data_wr,
  input  logic [DW-1:0]   data_wbyte,
  input  logic [PA_W-1:0] fetch_addr,
  output logic            start_data,
  output logic            start_fetch,
  output logic            xfer_done,
  output logic            cyc_data,
  output logic [PA_W-1:0] bus_addr,
  output logic [DW-1:0]   bus_dout,
  output logic            bus_ale,
  output logic            bus_rd,
  output logic            bus_wr,
  output logic            bus_drive,
  output logic            hlda
);
  bus_st_e st, st_nx;
  logic    boundary;
  logic    wr_q, wr_nx;
  logic    strobe_nx;

  assign boundary    = (st == ST_IDLE) || (st == ST_T4);
  assign start_data  = boundary && !hold && data_pend;
  assign start_fetch = boundary && !hold && !data_pend && fetch_ok;
  assign xfer_done   = ((st == ST_T3) || (st == ST_TW)) && bus_ready;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE, ST_T4: begin
        if (hold)                            st_nx = ST_HOLD;
        else if (start_data || start_fetch)  st_nx = ST_T1;
        else                                 st_nx = ST_IDLE;
      end
      ST_T1:   st_nx = ST_T2;
      ST_T2:   st_nx = ST_T3;
      ST_T3:   st_nx = bus_ready ? ST_T4 : ST_TW;
      ST_TW:   st_nx = bus_ready ? ST_T4 : ST_TW;
      ST_HOLD: st_nx = hold ? ST_HOLD : ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    if (start_data)       wr_nx = data_wr;
    else if (start_fetch) wr_nx = 1'b0;
    else                  wr_nx = wr_q;
    strobe_nx = (st_nx == ST_T2) || (st_nx == ST_T3) || (st_nx == ST_TW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      wr_q      <= 1'b0;
      cyc_data  <= 1'b0;
      bus_addr  <= '0;
      bus_dout  <= '0;
      bus_ale   <= 1'b0;
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_drive <= 1'b1;
      hlda      <= 1'b0;
    end else begin
      st        <= st_nx;
      wr_q      <= wr_nx;
      if (start_data) begin
        cyc_data <= 1'b1;
        bus_addr <= data_addr;
        bus_dout <= data_wbyte;
      end else if (start_fetch) begin
        cyc_data <= 1'b0;
        bus_addr <= fetch_addr;
      end
      bus_ale   <= (st_nx == ST_T1);
      bus_rd    <= strobe_nx && !wr_nx;
      bus_wr    <= strobe_nx && wr_nx;
      bus_drive <= (st_nx != ST_HOLD);
      hlda      <= (st_nx == ST_HOLD);
    end
  end

  // R3: address phase is followed by a strobe
  p_ale_then_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> (bus_rd || bus_wr));
  // R3: strobes are exclusive
  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr));
  // R4: a low ready in T3 inserts a wait state
  p_wait_insert_r4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_T3 && !bus_ready) |=> (st == ST_TW));
  // R9: acknowledge only rises after a boundary state
  p_hold_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> !$past(bus_rd) && !$past(bus_wr) && !$past(bus_ale));
  // R9: bus is released while acknowledged
  p_hold_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!bus_drive && !bus_ale && !bus_rd && !bus_wr));
  // R9: release on the clock after hold drops
  p_hold_release_r9: assert property (@(posedge clk) disable iff (rst)
    (hlda && !hold) |=> !hlda);
endmodule

// File: rtl/bytebus_biu.sv
module bytebus_biu #(
  parameter int          SEG_W  = 16,
  parameter int          PA_W   = 20,
  parameter int          SHIFT  = 4,
  parameter int          QDEPTH = 4,
  parameter logic [15:0] RST_CS = 16'hF000,
  parameter logic [15:0] RST_IP = 16'h0100
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_word,
  input  logic [SEG_W-1:0] req_seg,
  input  logic [SEG_W-1:0] req_off,
  input  logic [2*8-1:0]   req_wdata,
  output logic             rsp_valid,
  output logic [2*8-1:0]   rsp_rdata,
  input  logic             jmp_valid,
  input  logic [SEG_W-1:0] jmp_seg,
  input  logic [SEG_W-1:0] jmp_off,
  output logic             q_valid,
  input  logic             q_ready,
  output logic [7:0]       q_byte,
  output logic [PA_W-1:0]  bus_addr,
  output logic [7:0]       bus_dout,
  input  logic [7:0]       bus_din,
  output logic             bus_ale,
  output logic             bus_rd,
  output logic             bus_wr,
  input  logic             bus_ready,
  output logic             bus_drive,
  input  logic             hold,
  output logic             hlda
);
  localparam int BW = 8;

  // data transaction state
  logic             dat_busy, dat_wr, dat_word, dat_idx;
  logic [SEG_W-1:0] dat_seg, dat_off;
  logic [2*BW-1:0]  dat_wdata;
  logic [BW-1:0]    rdata_lo;
  logic             req_fire, data_pend;
  logic [SEG_W-1:0] cur_seg, cur_off;
  logic [BW-1:0]    cur_wbyte;
  logic             cur_wr;

  // code stream state
  logic [SEG_W-1:0] cs_q, ip_q;
  logic             drop_q;

  logic [PA_W-1:0]  data_pa, fetch_pa;
  logic             start_data, start_fetch, xfer_done, cyc_data;
  logic             q_room, q_push;

  assign req_ready = !dat_busy;
  assign req_fire  = req_valid && !dat_busy;
  assign data_pend = dat_busy || req_valid;

  always_comb begin
    if (dat_busy) begin
      cur_seg   = dat_seg;
      cur_off   = dat_off + SEG_W'(dat_idx);
      cur_wbyte = dat_idx ? dat_wdata[2*BW-1:BW] : dat_wdata[BW-1:0];
      cur_wr    = dat_wr;
    end else begin
      cur_seg   = req_seg;
      cur_off   = req_off;
      cur_wbyte = req_wdata[BW-1:0];
      cur_wr    = req_write;
    end
  end

  biu_addr_gen #(.SEG_W(SEG_W), .OFF_W(SEG_W), .SHIFT(SHIFT), .PA_W(PA_W)) i_data_ag (
    .seg(cur_seg), .off(cur_off), .pa(data_pa));

  biu_addr_gen #(.SEG_W(SEG_W), .OFF_W(SEG_W), .SHIFT(SHIFT), .PA_W(PA_W)) i_code_ag (
    .seg(cs_q), .off(ip_q), .pa(fetch_pa));

  biu_bus_seq #(.PA_W(PA_W), .DW(BW)) i_seq (
    .clk(clk), .rst(rst), .hold(hold), .bus_ready(bus_ready),
    .data_pend(data_pend), .fetch_ok(q_room),
    .data_addr(data_pa), .data_wr(cur_wr), .data_wbyte(cur_wbyte),
    .fetch_addr(fetch_pa),
    .start_data(start_data), .start_fetch(start_fetch),
    .xfer_done(xfer_done), .cyc_data(cyc_data),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_ale(bus_ale),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_drive(bus_drive), .hlda(hlda));

  assign q_push = xfer_done && !cyc_data && !drop_q && !jmp_valid;

  biu_prefetch_q #(.DEPTH(QDEPTH), .W(BW)) i_q (
    .clk(clk), .rst(rst), .flush(jmp_valid),
    .push(q_push), .push_data(bus_din), .pop_req(q_ready),
    .not_empty(q_valid), .has_room(q_room), .head(q_byte));

  // data request tracking and response assembly
  always_ff @(posedge clk) begin
    if (rst) begin
      dat_busy  <= 1'b0;
      dat_wr    <= 1'b0;
      dat_word  <= 1'b0;
      dat_idx   <= 1'b0;
      dat_seg   <= '0;
      dat_off   <= '0;
      dat_wdata <= '0;
      rdata_lo  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (req_fire) begin
        dat_busy  <= 1'b1;
        dat_wr    <= req_write;
        dat_word  <= req_word;
        dat_idx   <= 1'b0;
        dat_seg   <= req_seg;
        dat_off   <= req_off;
        dat_wdata <= req_wdata;
      end else if (xfer_done && cyc_data) begin
        if (dat_word && !dat_idx) begin
          dat_idx  <= 1'b1;
          rdata_lo <= bus_din;
        end else begin
          dat_busy  <= 1'b0;
          rsp_valid <= 1'b1;
          if (dat_wr)        rsp_rdata <= '0;
          else if (dat_word) rsp_rdata <= {bus_din, rdata_lo};
          else               rsp_rdata <= {{BW{1'b0}}, bus_din};
        end
      end
    end
  end

  // code segment, fetch pointer and stale-fetch marker
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= RST_CS;
      ip_q   <= RST_IP;
      drop_q <= 1'b0;
    end else begin
      if (jmp_valid) begin
        cs_q <= jmp_seg;
        ip_q <= jmp_off;
      end else if (q_push) begin
        ip_q <= ip_q + 1'b1;
      end
      if (jmp_valid)                      drop_q <= 1'b1;
      else if (start_data || start_fetch) drop_q <= 1'b0;
    end
  end

  // R6: no prefetch starts while a data request waits
  p_data_first_r6: assert property (@(posedge clk) disable iff (rst)
    start_fetch |-> !data_pend);
  // R2: one completion pulse, never two in a row
  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R6: a new request is refused while one is outstanding
  p_one_outstanding_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/test_bytebus_biu.sv
module test_bytebus_biu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_seg = '0, req_off = '0, req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        jmp_valid = 1'b0;
  logic [15:0] jmp_seg = '0, jmp_off = '0;
  logic        q_valid, q_ready = 1'b0;
  logic [7:0]  q_byte;
  logic [19:0] bus_addr;
  logic [7:0]  bus_dout, bus_din;
  logic        bus_ale, bus_rd, bus_wr, bus_drive, hlda;
  logic        bus_ready = 1'b1, hold = 1'b0;
  logic        force_wait = 1'b0, rand_en = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bytebus_biu i_bytebus_biu (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_seg(req_seg),
    .req_off(req_off), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .jmp_valid(jmp_valid), .jmp_seg(jmp_seg),
    .jmp_off(jmp_off), .q_valid(q_valid), .q_ready(q_ready), .q_byte(q_byte),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_ready(bus_ready), .bus_drive(bus_drive), .hold(hold), .hlda(hlda));

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    logic [23:0] t;
    t = {4'h0, s, 4'h0} + {8'h00, o};
    return t[19:0];
  endfunction

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[19:16]} ^ 8'h5A;
  endfunction

  assign bus_din = mem_byte(bus_addr);

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // random handshake pins
  always @(posedge clk) begin
    #1;
    if (rand_en) begin
      bus_ready <= force_wait ? 1'b0 : (($urandom % 4) != 0);
      q_ready   <= (($urandom % 5) < 3);
    end
  end

  // monitor: all observation at the falling edge
  logic [15:0] exp_cs = 16'hF000, exp_ip = 16'h0100;
  logic [27:0] exp_wr[$];
  logic [15:0] exp_rd;
  bit          last_wr;
  bit          prio_arm = 0, chk_empty = 0;
  logic [19:0] prio_addr;
  int          strobe_len = 0, waits = 0;
  logic        p_rd = 0, p_wr = 0, p_ale = 0, p_hlda = 0, p_hold = 0;

  always @(negedge clk) begin
    if (!rst) begin
      // R8: queue empty after a flush clock
      if (chk_empty) chk(!q_valid, "R8 empty after flush", q_valid, 0);
      chk_empty = 0;
      // R7 / R5 / R1 / R8: popped bytes follow the code stream
      if (jmp_valid) begin
        exp_cs = jmp_seg; exp_ip = jmp_off; chk_empty = 1;
      end else if (q_valid && q_ready) begin
        chk(q_byte == mem_byte(phys(exp_cs, exp_ip)), "R7 R5 R1 code byte",
            q_byte, mem_byte(phys(exp_cs, exp_ip)));
        exp_ip = exp_ip + 1;
      end
      // R6: first address phase after acceptance is the data one
      if (bus_ale && prio_arm) begin
        chk(bus_addr == prio_addr, "R6 R1 data first", bus_addr, prio_addr);
        prio_arm = 0;
      end
      if (req_valid && req_ready) begin
        prio_arm  = 1;
        prio_addr = phys(req_seg, req_off);
        last_wr   = req_write;
        if (req_write) begin
          exp_wr.push_back({phys(req_seg, req_off), req_wdata[7:0]});
          if (req_word) exp_wr.push_back({phys(req_seg, req_off + 16'd1), req_wdata[15:8]});
        end else if (req_word) begin
          exp_rd = {mem_byte(phys(req_seg, req_off + 16'd1)), mem_byte(phys(req_seg, req_off))};
        end else begin
          exp_rd = {8'h00, mem_byte(phys(req_seg, req_off))};
        end
      end
      // R2: write bytes in order, low first
      if (bus_wr && !p_wr) begin
        if (exp_wr.size() == 0) chk(0, "R2 unexpected write", bus_addr, 0);
        else begin
          logic [27:0] e;
          e = exp_wr.pop_front();
          chk({bus_addr, bus_dout} == e, "R2 R1 write byte", {bus_addr, bus_dout}, e);
        end
      end
      // R2: read result
      if (rsp_valid && !last_wr) chk(rsp_rdata == exp_rd, "R2 read data", rsp_rdata, exp_rd);
      // R3 / R4: strobe length equals 2 + wait samples
      if (bus_rd || bus_wr) begin
        strobe_len++;
        if (strobe_len >= 2 && !bus_ready) waits++;
      end else if (p_rd || p_wr) begin
        chk(strobe_len == 2 + waits, "R4 R3 strobe length", strobe_len, 2 + waits);
        strobe_len = 0; waits = 0;
      end
      if (bus_rd && bus_wr) chk(0, "R3 both strobes", 1, 0);
      if (p_ale) chk(bus_rd || bus_wr, "R3 strobe after address phase", 0, 1);
      // R9: hold behaviour
      if (hlda) chk(!bus_drive && !bus_rd && !bus_wr && !bus_ale, "R9 bus released",
                    {bus_drive, bus_rd, bus_wr, bus_ale}, 0);
      if (hlda && !p_hlda) chk(!p_rd && !p_wr && !p_ale, "R9 grant at boundary",
                               {p_rd, p_wr, p_ale}, 0);
      if (p_hlda && !p_hold) chk(!hlda, "R9 release", hlda, 0);
    end
    p_rd = bus_rd; p_wr = bus_wr; p_ale = bus_ale; p_hlda = hlda; p_hold = hold;
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_req(input bit w, input bit wd, input logic [15:0] s,
                        input logic [15:0] o, input logic [15:0] d);
    req_valid = 1; req_write = w; req_word = wd; req_seg = s; req_off = o; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    while (!rsp_valid) @(negedge clk);
    tick(1);
  endtask

  task automatic do_jmp(input logic [15:0] s, input logic [15:0] o);
    jmp_valid = 1; jmp_seg = s; jmp_off = o;
    tick(1);
    jmp_valid = 0;
  endtask

  task automatic do_hold(input int len);
    hold = 1;
    @(negedge clk);
    while (!hlda) @(negedge clk);
    tick(len);
    hold = 0;
    tick(2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    tick(3);
    @(negedge clk);
    // R10: reset values
    chk(!hlda && !q_valid && !rsp_valid && !bus_ale && !bus_rd && !bus_wr,
        "R10 reset outputs low", {hlda, q_valid, rsp_valid, bus_ale, bus_rd, bus_wr}, 0);
    chk(req_ready && bus_drive, "R10 reset outputs high", {req_ready, bus_drive}, 2'b11);
    @(posedge clk); #1;
    rst = 0;
    // R5: first fetch address at reset code position
    @(negedge clk);
    while (!bus_ale) @(negedge clk);
    chk(bus_addr == phys(16'hF000, 16'h0100), "R5 R10 first fetch", bus_addr,
        phys(16'hF000, 16'h0100));
    rand_en = 1;
    // directed corners: offset and address wrap
    do_req(0, 1, 16'hFFFF, 16'hFFFF, 16'h0);
    do_req(1, 1, 16'hFFFF, 16'hFFFF, 16'hA55A);
    do_req(0, 0, 16'h1234, 16'h0010, 16'h0);
    // long wait state stretch
    force_wait = 1; tick(6); force_wait = 0;
    do_req(1, 0, 16'h0040, 16'h8001, 16'h00C3);
    // hold in the middle of traffic
    do_hold(4);
    do_jmp(16'h2000, 16'hFFFE);
    tick(20);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom % 8;
      case (op)
        0, 1: do_req(0, $urandom % 2, 16'($urandom), 16'($urandom), 16'h0);
        2, 3: do_req(1, $urandom % 2, 16'($urandom), 16'($urandom), 16'($urandom));
        4:    do_jmp(16'($urandom), 16'($urandom));
        5:    do_hold(1 + $urandom % 4);
        6:    begin force_wait = 1; tick(1 + $urandom % 4); force_wait = 0; end
        default: tick(1 + $urandom % 8);
      endcase
    end
    tick(30);
    chk(exp_wr.size() == 0, "R2 all writes seen", exp_wr.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R3 actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule